// File: doc/BRIEF.md
# Single-to-Double Interrupt Acknowledge Sequencer

This block sits between a host-side bus and a cascaded pair of interrupt controllers. The host bus delivers an interrupt acknowledge as one transaction. The controllers need two acknowledge strobes: the first freezes their priority state, and the second makes them place the 8-bit vector on their data lines. The sequencer accepts the single request and issues the two active-low strobes on an internal net. It samples the vector during the second strobe and hands the vector back with a one-clock ready. The requester keeps its request raised and waits until that ready arrives.

Each strobe lasts a run-time selectable number of clocks, taken from a small length input when the request is accepted. A fixed idle stretch of at least one clock separates the two strobes. During that stretch the controllers can pass their cascade identification between themselves. The sequence always takes the same minimum number of clocks, because the requester is stalled for all of it.

Top module: `iack_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `inta_n` = 1, `ack_rdy` = 0 and `ack_data` = 0x00.
- R2: Each accepted request produces exactly two falling edges on `inta_n` before its `ack_rdy`.
- R3: Each strobe holds `inta_n` low for exactly `cfg_pulse` + 1 consecutive clocks. The value of `cfg_pulse` is taken at the edge that accepts the request, and later changes to it do not affect the conversion in progress.
- R4: Between the two strobes, `inta_n` is high for exactly `GAP_CLKS` clocks, where `GAP_CLKS` is at least 1.
- R5: The first strobe starts in the cycle after the accepting edge. `ack_rdy` is high for exactly one clock, starting 2*(`cfg_pulse`+1)+`GAP_CLKS` clocks after the accepting edge, and is never high earlier.
- R6: While `ack_rdy` is high, `ack_data` equals the value of `ctl_vec` at the edge that ends the last low clock of the second strobe. Values of `ctl_vec` at other edges have no effect. `ack_data` is 0x00 whenever `ack_rdy` is low.
- R7: A request held high during a conversion does not start a second one. The cycle after `ack_rdy` is idle, with `inta_n` high and `ack_rdy` low. If the request is still high at the end of that idle cycle, a new conversion starts.
- R8: Reset in the middle of a conversion abandons it: `inta_n` returns high and no `ack_rdy` follows.
- R9: While idle with `ack_req` low, `inta_n` stays high and `ack_rdy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_req | input | 1 | Acknowledge request from the host side, held until `ack_rdy` |
| cfg_pulse | input | CFG_W | Strobe length minus one, sampled at acceptance |
| ctl_vec | input | VEC_W | Vector driven by the controllers |
| inta_n | output | 1 | Internal active-low acknowledge strobe to the controllers |
| ack_rdy | output | 1 | One-clock completion of the request |
| ack_data | output | VEC_W | Captured vector, valid with `ack_rdy` |

## Verification
A table of conversions covers the shortest and the longest strobe length, several middle lengths, and vectors of all zeros, all ones and mixed bits. This shows that the length comes from `cfg_pulse` and not from a fixed constant, and that no vector bit is lost. On every clock except the capture edge, `ctl_vec` and `cfg_pulse` are driven with junk. A capture one clock early or late, or a length re-read during the conversion, therefore shows up as a wrong value. Directed cases separate three behaviours: a request held across two back-to-back conversions, a quiet idle bus, and a reset in the middle of a strobe.

// File: rtl/iack_seq_pkg.sv
package iack_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PULSE1 = 3'd1,
    S_GAP    = 3'd2,
    S_PULSE2 = 3'd3,
    S_DONE   = 3'd4
  } iack_state_e;

  // clocks a strobe stays low for a given length setting
  function automatic int strobe_clocks(input int cfg);
    return cfg + 1;
  endfunction

  // clocks from the accepting edge to the ready cycle
  function automatic int conv_cycles(input int cfg, input int gap);
    return 2 * strobe_clocks(cfg) + gap;
  endfunction

endpackage

// File: rtl/iack_timer.sv
module iack_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/iack_vec_cap.sv
module iack_vec_cap #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [VW-1:0] vec_in,
  output logic [VW-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (rst)          vec_q <= '0;
    else if (capture) vec_q <= vec_in;
  end

  AST_CAP_TAKES: assert property (@(posedge clk) disable iff (rst)
    capture |=> (vec_q == $past(vec_in))); // R6

endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_seq_pkg::*;
#(
  parameter int CFG_W    = 3,
  parameter int VEC_W    = 8,
  parameter int GAP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_req,
  input  logic [CFG_W-1:0] cfg_pulse,
  input  logic [VEC_W-1:0] ctl_vec,
  output logic             inta_n,
  output logic             ack_rdy,
  output logic [VEC_W-1:0] ack_data
);
  localparam int GAP_W = $clog2(GAP_CLKS) + 1;
  localparam int TW    = (CFG_W > GAP_W) ? CFG_W : GAP_W;
  localparam int RUN_W = $clog2(2 * (1 << CFG_W) + GAP_CLKS + 2) + 1;
  localparam logic [TW-1:0] GAP_LOAD = TW'(GAP_CLKS - 1);

  iack_state_e      state_q, state_d;
  logic [CFG_W-1:0] len_q;
  logic             tmr_load, tmr_expired;
  logic [TW-1:0]    tmr_val;
  logic             cap_now;
  logic [VEC_W-1:0] vec_q;

  // named internal events
  logic accept_ev, strobe_end_ev;
  assign accept_ev     = (state_q == S_IDLE) && ack_req;
  assign strobe_end_ev = ((state_q == S_PULSE1) || (state_q == S_PULSE2)) && tmr_expired;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE: if (ack_req) begin
        state_d  = S_PULSE1;
        tmr_load = 1'b1;
        tmr_val  = TW'(cfg_pulse);
      end
      S_PULSE1: if (tmr_expired) begin
        state_d  = S_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LOAD;
      end
      S_GAP: if (tmr_expired) begin
        state_d  = S_PULSE2;
        tmr_load = 1'b1;
        tmr_val  = TW'(len_q);
      end
      S_PULSE2: if (tmr_expired) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_ev) len_q <= cfg_pulse;
    end
  end

  iack_timer #(.W(TW)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign cap_now = (state_q == S_PULSE2) && tmr_expired;

  iack_vec_cap #(.VW(VEC_W)) cap_i (
    .clk     (clk),
    .rst     (rst),
    .capture (cap_now),
    .vec_in  (ctl_vec),
    .vec_q   (vec_q)
  );

  assign inta_n   = !((state_q == S_PULSE1) || (state_q == S_PULSE2));
  assign ack_rdy  = (state_q == S_DONE);
  assign ack_data = ack_rdy ? vec_q : '0;

  // observation counters for the properties below
  logic             inta_q;
  logic             fall_ev;
  logic [1:0]       fall_cnt;
  logic [CFG_W+1:0] low_run;
  logic [GAP_W+1:0] high_run;
  logic [RUN_W-1:0] run_cnt;

  assign fall_ev = inta_q && !inta_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      inta_q   <= 1'b1;
      fall_cnt <= '0;
      low_run  <= '0;
      high_run <= '0;
      run_cnt  <= '0;
    end else begin
      inta_q   <= inta_n;
      fall_cnt <= (state_q == S_IDLE) ? 2'd0 : fall_cnt + {1'b0, fall_ev};
      low_run  <= inta_n ? '0 : low_run + 1'b1;
      high_run <= (!inta_n || state_q == S_IDLE) ? '0 : high_run + 1'b1;
      run_cnt  <= (state_q == S_IDLE) ? '0 : run_cnt + 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inta_n && !ack_rdy && ack_data == '0)); // R1
  AST_TWO_STROBES: assert property (@(posedge clk) disable iff (rst)
    ack_rdy |-> (fall_cnt == 2'd2)); // R2
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(inta_n) && !$past(rst)) |-> (int'(low_run) == strobe_clocks(int'(len_q)))); // R3
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (rst)
    (fall_ev && fall_cnt == 2'd1) |-> (int'(high_run) == GAP_CLKS)); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ack_rdy |-> (int'(run_cnt) == conv_cycles(int'(len_q), GAP_CLKS))); // R5
  AST_VEC_RETURN: assert property (@(posedge clk) disable iff (rst)
    (ack_rdy && !$past(rst)) |-> (ack_data == $past(ctl_vec))); // R6
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack_rdy |=> (!ack_rdy && inta_n)); // R7
  AST_STROBE_END: assert property (@(posedge clk) disable iff (rst)
    (strobe_end_ev && state_q == S_PULSE2) |=> ack_rdy); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q == S_IDLE && !ack_req) && !$past(rst)) |-> (inta_n && !ack_rdy)); // R9

endmodule

// File: tb/iack_seq_tb_top.sv
module iack_seq_tb_top;
  localparam int CFG_W = 3;
  localparam int VEC_W = 8;
  localparam int GAP   = 2;

  logic clk = 1'b0;
  logic rst;
  logic ack_req;
  logic [CFG_W-1:0] cfg_pulse;
  logic [VEC_W-1:0] ctl_vec;
  logic inta_n, ack_rdy;
  logic [VEC_W-1:0] ack_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  iack_seq #(.CFG_W(CFG_W), .VEC_W(VEC_W), .GAP_CLKS(GAP)) dut_i (
    .clk(clk), .rst(rst), .ack_req(ack_req), .cfg_pulse(cfg_pulse),
    .ctl_vec(ctl_vec), .inta_n(inta_n), .ack_rdy(ack_rdy), .ack_data(ack_data)
  );

  // {length setting, vector}
  localparam logic [15:0] VEC_TAB [6] = '{
    16'h0008, 16'h01A5, 16'h035A, 16'h07FF, 16'h0200, 16'h0571
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the idle cycle after ready
  task automatic run_xfer(input int cfg, input logic [7:0] vec, input bit keep);
    int len, last, bad, falls, early;
    logic prev;
    len = cfg + 1;
    last = 2 * len + GAP;
    bad = 0; falls = 0; early = 0; prev = 1'b1;
    cfg_pulse = CFG_W'(cfg);
    ack_req = 1'b1;
    ctl_vec = ~vec;
    for (int j = 1; j <= last + 1; j++) begin
      @(negedge clk);
      if (j <= last) begin
        bit exp_low;
        exp_low = (j <= len) || (j > len + GAP);
        if (inta_n !== !exp_low) bad++;
        if (prev && !inta_n) falls++;
        prev = inta_n;
        if (ack_rdy) early++;
      end else begin
        chk(ack_rdy === 1'b1, "R5", "ready at expected cycle", ack_rdy, 1);
        chk(ack_data === vec, "R6", "returned vector", ack_data, vec);
        ack_req = keep;
      end
      cfg_pulse = CFG_W'(cfg ^ j);
      ctl_vec = (j == last) ? vec : (~vec ^ 8'(j));
    end
    chk(bad == 0, "R3", "strobe/gap shape mismatches (R4)", bad, 0);
    chk(falls == 2, "R2", "strobe count", falls, 2);
    chk(early == 0, "R5", "early ready cycles", early, 0);
    @(negedge clk);
    chk(ack_rdy === 1'b0 && inta_n === 1'b1, "R7", "idle after ready",
        {ack_rdy, inta_n}, 1);
  endtask

  bit done = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ack_req = 1'b0; cfg_pulse = '0; ctl_vec = '0;
    repeat (3) @(negedge clk);
    chk(inta_n === 1'b1 && ack_rdy === 1'b0 && ack_data === 8'h00, "R1",
        "reset outputs", {inta_n, ack_rdy, ack_data}, 512);
    rst = 1'b0;

    // R9: idle without request
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(inta_n === 1'b1 && ack_rdy === 1'b0, "R9", "quiet idle",
          {inta_n, ack_rdy}, 2);
    end

    // table walk; entry 2 keeps the request for a back-to-back (R7)
    for (int i = 0; i < 6; i++)
      run_xfer(int'(VEC_TAB[i][15:8]), VEC_TAB[i][7:0], i == 2);

    // R8: reset in the middle of the first strobe
    cfg_pulse = 3'd3; ack_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(inta_n === 1'b0, "R8", "strobe active before reset", inta_n, 0);
    rst = 1'b1; ack_req = 1'b0;
    @(negedge clk);
    chk(inta_n === 1'b1 && ack_rdy === 1'b0, "R8", "strobe dropped by reset",
        {inta_n, ack_rdy}, 2);
    rst = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (ack_rdy !== 1'b0 || inta_n !== 1'b1) seen++;
      end
      chk(seen == 0, "R8", "no completion after abort", seen, 0);
    end
    run_xfer(0, 8'h3C, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule